// File: doc/BRIEF.md
# Nested-Loop Dual-Address Transfer Engine

This block carries out one channel's memory-to-memory transfer. Each data beat is a read from a source address followed by a write to a destination address. A descriptor is presented at the configuration inputs and captured on a start pulse. It holds the two start addresses, a signed per-beat stride for each side, a beat size, a minor-loop byte count, a major iteration count, and a signed final adjustment for each address.

The work is organised as two nested loops. The inner (minor) loop moves the minor byte count. Read data is gathered into a staging buffer of up to 16 bytes, and that buffer is then drained to the destination. After every minor loop the major count drops by one and a one-cycle minor-done pulse is raised. Before the next minor loop may begin, the channel must be granted again. When the major count reaches zero, the final adjustments are added to both addresses and a one-cycle done pulse is raised. A bus error ends the transfer at once and leaves the live addresses and count visible on the status outputs.

Top module: `dma_nested_engine`

## Requirements
- R1: Every beat is a read on the source port followed later by a write on the destination port. Write data equals the read data, unchanged and in read order, and the write count equals the read count.
- R2: Both addresses advance after each completed beat by their own signed per-beat offset, and an offset of zero is allowed. Write k (counting from 0) goes to daddr+k*doff and carries the word read from saddr+k*soff.
- R3: Reads are staged in chunks. Within a minor loop, the engine reads min(beats left, 16/beat_bytes) beats before writing any of them. The staging buffer never holds more than 16 bytes.
- R4: The size code gives the beat width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, and 3 is reserved. A minor loop moves nbytes/beat_bytes beats and ends with minor_done_o high for exactly one cycle.
- R5: After a start, and after every minor loop that is not the last, no read is issued until grant_i has been seen high.
- R6: The major count decrements once per minor loop. When it reaches zero, done_o pulses for one cycle, cur_citer_o reads 0 and busy_o falls.
- R7: On completion, cur_saddr_o equals saddr+total_beats*soff+slast, and cur_daddr_o equals daddr+total_beats*doff+dlast.
- R8: A start with size code 3, a zero byte count, a byte count that is not a multiple of the beat width, or a zero major count sets cfg_err_o and starts no bus activity. An accepted start clears cfg_err_o.
- R9: A read or write error response stops the transfer at once and sets err_o, and no done pulse follows. The addresses hold the value of the failing beat, and the major count holds the number of minor loops still unfinished.
- R10: While a request is valid and not ready, its address (and, for writes, its data) stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture descriptor and begin (ignored while busy) |
| cfg_saddr_i | input | AW | Source start address |
| cfg_daddr_i | input | AW | Destination start address |
| cfg_soff_i | input | OFF_W | Signed source stride per beat |
| cfg_doff_i | input | OFF_W | Signed destination stride per beat |
| cfg_size_i | input | 2 | Beat size code |
| cfg_nbytes_i | input | NBYTES_W | Minor-loop byte count |
| cfg_citer_i | input | CITER_W | Major iteration count |
| cfg_slast_i | input | AW | Signed source adjustment at completion |
| cfg_dlast_i | input | AW | Signed destination adjustment at completion |
| grant_i | input | 1 | Channel grant for the next minor loop |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | AW | Read address |
| rd_size_o | output | 2 | Read beat size code |
| rd_ready_i | input | 1 | Read completes this cycle |
| rd_data_i | input | DW | Read data |
| rd_err_i | input | 1 | Read error response |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | AW | Write address |
| wr_size_o | output | 2 | Write beat size code |
| wr_data_o | output | DW | Write data |
| wr_ready_i | input | 1 | Write completes this cycle |
| wr_err_i | input | 1 | Write error response |
| busy_o | output | 1 | Transfer in progress |
| minor_done_o | output | 1 | One-cycle pulse per finished minor loop |
| done_o | output | 1 | One-cycle pulse when major count reaches zero |
| err_o | output | 1 | Sticky bus error flag |
| cfg_err_o | output | 1 | Sticky configuration error flag |
| cur_saddr_o | output | AW | Live source address |
| cur_daddr_o | output | AW | Live destination address |
| cur_citer_o | output | CITER_W | Live major count |

## Verification
The hardest situation to reach from the ports is an error response that lands partway through a later minor loop. Only there do the held addresses and the partly decremented major count show whether the failing beat was counted. The bench aims a read error, and separately a write error, at a chosen global beat index, and the responders count handshakes to hit it. Chunk staging is exercised with 1-byte beats and a 40-byte minor loop, which produces chunks of 16, 16 and 8. Random grant delays hold the engine in its grant wait after each minor loop.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } beat_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GRANT,
    ST_READ,
    ST_WRITE
  } eng_state_e;
endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check #(
  parameter int NBYTES_W = 16,
  parameter int CITER_W  = 12
) (
  input  logic [1:0]          size_i,
  input  logic [NBYTES_W-1:0] nbytes_i,
  input  logic [CITER_W-1:0]  citer_i,
  output logic                ok_o
);
  import dma_eng_pkg::*;

  logic aligned;

  always_comb begin
    unique case (beat_size_e'(size_i))
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = (nbytes_i[0] == 1'b0);
      SZ_WORD: aligned = (nbytes_i[1:0] == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

  assign ok_o = aligned && (nbytes_i != '0) && (citer_i != '0);
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic [LVL_W-1:0] level_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [IDX_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (clear_i || (pop_i && level_q == LVL_W'(1))) begin
      // chunk fully drained: rewind so the next chunk starts at slot 0
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + IDX_W'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + IDX_W'(1);
      level_q <= level_q + LVL_W'(push_i) - LVL_W'(pop_i);
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> level_q < LVL_W'(DEPTH)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> level_q != '0); // R3
  AST_NO_PUSH_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R1
endmodule

// File: rtl/dma_nested_engine.sv
module dma_nested_engine #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int OFF_W       = 16,
  parameter int NBYTES_W    = 16,
  parameter int CITER_W     = 12,
  parameter int BURST_BYTES = 16,
  localparam int LVL_W = $clog2(BURST_BYTES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [AW-1:0]       cfg_saddr_i,
  input  logic [AW-1:0]       cfg_daddr_i,
  input  logic [OFF_W-1:0]    cfg_soff_i,
  input  logic [OFF_W-1:0]    cfg_doff_i,
  input  logic [1:0]          cfg_size_i,
  input  logic [NBYTES_W-1:0] cfg_nbytes_i,
  input  logic [CITER_W-1:0]  cfg_citer_i,
  input  logic [AW-1:0]       cfg_slast_i,
  input  logic [AW-1:0]       cfg_dlast_i,
  input  logic                grant_i,
  output logic                rd_valid_o,
  output logic [AW-1:0]       rd_addr_o,
  output logic [1:0]          rd_size_o,
  input  logic                rd_ready_i,
  input  logic [DW-1:0]       rd_data_i,
  input  logic                rd_err_i,
  output logic                wr_valid_o,
  output logic [AW-1:0]       wr_addr_o,
  output logic [1:0]          wr_size_o,
  output logic [DW-1:0]       wr_data_o,
  input  logic                wr_ready_i,
  input  logic                wr_err_i,
  output logic                busy_o,
  output logic                minor_done_o,
  output logic                done_o,
  output logic                err_o,
  output logic                cfg_err_o,
  output logic [AW-1:0]       cur_saddr_o,
  output logic [AW-1:0]       cur_daddr_o,
  output logic [CITER_W-1:0]  cur_citer_o
);
  import dma_eng_pkg::*;

  eng_state_e          state_q;
  logic [AW-1:0]       saddr_q, daddr_q, slast_q, dlast_q;
  logic [OFF_W-1:0]    soff_q, doff_q;
  logic [1:0]          size_q;
  logic [NBYTES_W-1:0] nbytes_q, left_q;
  logic [CITER_W-1:0]  citer_q;
  logic                err_q, cfg_err_q, minor_done_q, done_q;

  logic                cfg_ok, accept;
  logic [NBYTES_W-1:0] beat_bytes;
  logic [LVL_W-1:0]    cap_beats, buf_level;
  logic [DW-1:0]       buf_head;
  logic [AW-1:0]       saddr_step, daddr_step;
  logic                push, pop, chunk_full, last_rd;

  dma_cfg_check #(.NBYTES_W(NBYTES_W), .CITER_W(CITER_W)) u_cfg_check (
    .size_i  (cfg_size_i),
    .nbytes_i(cfg_nbytes_i),
    .citer_i (cfg_citer_i),
    .ok_o    (cfg_ok)
  );

  assign accept = (state_q == ST_IDLE) && start_i && cfg_ok;
  assign push   = (state_q == ST_READ) && rd_ready_i && !rd_err_i;
  assign pop    = (state_q == ST_WRITE) && wr_ready_i && !wr_err_i;

  dma_stage_buf #(.DW(DW), .DEPTH(BURST_BYTES)) u_stage_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .push_i     (push),
    .push_data_i(rd_data_i),
    .pop_i      (pop),
    .head_o     (buf_head),
    .level_o    (buf_level)
  );

  assign beat_bytes = NBYTES_W'(1) << size_q;
  assign cap_beats  = LVL_W'(BURST_BYTES >> size_q);
  assign chunk_full = (buf_level + LVL_W'(1)) == cap_beats;
  assign last_rd    = (left_q == beat_bytes);
  assign saddr_step = saddr_q + {{(AW-OFF_W){soff_q[OFF_W-1]}}, soff_q};
  assign daddr_step = daddr_q + {{(AW-OFF_W){doff_q[OFF_W-1]}}, doff_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      saddr_q      <= '0;
      daddr_q      <= '0;
      slast_q      <= '0;
      dlast_q      <= '0;
      soff_q       <= '0;
      doff_q       <= '0;
      size_q       <= '0;
      nbytes_q     <= '0;
      left_q       <= '0;
      citer_q      <= '0;
      err_q        <= 1'b0;
      cfg_err_q    <= 1'b0;
      minor_done_q <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      minor_done_q <= 1'b0;
      done_q       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (cfg_ok) begin
              saddr_q   <= cfg_saddr_i;
              daddr_q   <= cfg_daddr_i;
              slast_q   <= cfg_slast_i;
              dlast_q   <= cfg_dlast_i;
              soff_q    <= cfg_soff_i;
              doff_q    <= cfg_doff_i;
              size_q    <= cfg_size_i;
              nbytes_q  <= cfg_nbytes_i;
              citer_q   <= cfg_citer_i;
              err_q     <= 1'b0;
              cfg_err_q <= 1'b0;
              state_q   <= ST_GRANT;
            end else begin
              cfg_err_q <= 1'b1;
            end
          end
        end
        ST_GRANT: begin
          if (grant_i) begin
            left_q  <= nbytes_q;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_ready_i) begin
            if (rd_err_i) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              saddr_q <= saddr_step;
              left_q  <= left_q - beat_bytes;
              if (last_rd || chunk_full) state_q <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (wr_ready_i) begin
            if (wr_err_i) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else if (buf_level == LVL_W'(1)) begin
              if (left_q == '0) begin
                minor_done_q <= 1'b1;
                citer_q      <= citer_q - CITER_W'(1);
                if (citer_q == CITER_W'(1)) begin
                  done_q  <= 1'b1;
                  saddr_q <= saddr_q + slast_q;
                  daddr_q <= daddr_step + dlast_q;
                  state_q <= ST_IDLE;
                end else begin
                  daddr_q <= daddr_step;
                  state_q <= ST_GRANT;
                end
              end else begin
                daddr_q <= daddr_step;
                state_q <= ST_READ;
              end
            end else begin
              daddr_q <= daddr_step;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid_o   = (state_q == ST_READ);
  assign rd_addr_o    = saddr_q;
  assign rd_size_o    = size_q;
  assign wr_valid_o   = (state_q == ST_WRITE);
  assign wr_addr_o    = daddr_q;
  assign wr_size_o    = size_q;
  assign wr_data_o    = buf_head;
  assign busy_o       = (state_q != ST_IDLE);
  assign minor_done_o = minor_done_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign cfg_err_o    = cfg_err_q;
  assign cur_saddr_o  = saddr_q;
  assign cur_daddr_o  = daddr_q;
  assign cur_citer_o  = citer_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o)); // R10
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R10
  AST_DONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cur_citer_o == '0 && minor_done_o && !busy_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_MINOR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    minor_done_o |=> !minor_done_o); // R4
  AST_NO_GRANT_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_GRANT && !grant_i |=> !rd_valid_o); // R5
  AST_CFG_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> !busy_o); // R8
  AST_ERR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !rd_valid_o && !wr_valid_o && !done_o); // R9
endmodule

// File: tb/dma_nested_engine_bench.sv
`timescale 1ns/1ps
module dma_nested_engine_bench;
  localparam int AW = 32, DW = 32, OFF_W = 16, NBYTES_W = 16, CITER_W = 12, BURST = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic                start_i = 1'b0, grant_i = 1'b0;
  logic [AW-1:0]       cfg_saddr_i = '0, cfg_daddr_i = '0, cfg_slast_i = '0, cfg_dlast_i = '0;
  logic [OFF_W-1:0]    cfg_soff_i = '0, cfg_doff_i = '0;
  logic [1:0]          cfg_size_i = '0;
  logic [NBYTES_W-1:0] cfg_nbytes_i = '0;
  logic [CITER_W-1:0]  cfg_citer_i = '0;
  logic                rd_valid_o, wr_valid_o, rd_ready_i = 1'b0, rd_err_i = 1'b0;
  logic                wr_ready_i = 1'b0, wr_err_i = 1'b0;
  logic [AW-1:0]       rd_addr_o, wr_addr_o, cur_saddr_o, cur_daddr_o;
  logic [1:0]          rd_size_o, wr_size_o;
  logic [DW-1:0]       rd_data_i = '0, wr_data_o;
  logic                busy_o, minor_done_o, done_o, err_o, cfg_err_o;
  logic [CITER_W-1:0]  cur_citer_o;

  dma_nested_engine u_dma_nested_engine (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .cfg_saddr_i(cfg_saddr_i), .cfg_daddr_i(cfg_daddr_i),
    .cfg_soff_i(cfg_soff_i), .cfg_doff_i(cfg_doff_i), .cfg_size_i(cfg_size_i),
    .cfg_nbytes_i(cfg_nbytes_i), .cfg_citer_i(cfg_citer_i),
    .cfg_slast_i(cfg_slast_i), .cfg_dlast_i(cfg_dlast_i), .grant_i(grant_i),
    .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .rd_size_o(rd_size_o),
    .rd_ready_i(rd_ready_i), .rd_data_i(rd_data_i), .rd_err_i(rd_err_i),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_size_o(wr_size_o),
    .wr_data_o(wr_data_o), .wr_ready_i(wr_ready_i), .wr_err_i(wr_err_i),
    .busy_o(busy_o), .minor_done_o(minor_done_o), .done_o(done_o), .err_o(err_o),
    .cfg_err_o(cfg_err_o), .cur_saddr_o(cur_saddr_o), .cur_daddr_o(cur_daddr_o),
    .cur_citer_o(cur_citer_o)
  );

  int checks = 0, errors = 0;
  int rd_cnt, wr_cnt, rd_before, minor_cnt, done_cnt, grant_viol, rd_err_at, wr_err_at;
  bit first_wr, waiting;
  logic [31:0] wl_addr [0:1023];
  logic [31:0] wl_data [0:1023];

  function automatic logic [31:0] pat(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h00C0FFEE;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // responders and monitors, all on the falling edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (minor_done_o) minor_cnt++;
      if (done_o) done_cnt++;
      if (waiting && rd_valid_o) grant_viol++;
      if (minor_done_o && !done_o) waiting = 1'b1;
      grant_i = waiting && ($urandom % 4 == 0);
      if (grant_i) waiting = 1'b0;
      rd_ready_i = 1'b0; rd_err_i = 1'b0;
      if (rd_valid_o && ($urandom % 3 != 0)) begin
        rd_ready_i = 1'b1;
        rd_data_i  = pat(rd_addr_o);
        if (rd_cnt == rd_err_at) rd_err_i = 1'b1;
        rd_cnt++;
        if (!first_wr) rd_before++;
      end
      wr_ready_i = 1'b0; wr_err_i = 1'b0;
      if (wr_valid_o && ($urandom % 3 != 0)) begin
        wr_ready_i = 1'b1;
        if (wr_cnt == wr_err_at) wr_err_i = 1'b1;
        else if (wr_cnt < 1024) begin
          wl_addr[wr_cnt] = wr_addr_o;
          wl_data[wr_cnt] = wr_data_o;
        end
        wr_cnt++;
        first_wr = 1'b1;
      end
    end
  end

  task automatic run(input logic [31:0] sa, input logic [31:0] da, input int so, input int dof,
                     input int nb, input int ci, input int sz, input int sl, input int dl,
                     input int rerr, input int werr);
    int bpm, total, cap, bad, exp_before;
    rd_cnt = 0; wr_cnt = 0; rd_before = 0; minor_cnt = 0; done_cnt = 0; grant_viol = 0;
    first_wr = 1'b0; rd_err_at = rerr; wr_err_at = werr;
    @(negedge clk);
    cfg_saddr_i = sa; cfg_daddr_i = da; cfg_soff_i = OFF_W'(so); cfg_doff_i = OFF_W'(dof);
    cfg_nbytes_i = NBYTES_W'(nb); cfg_citer_i = CITER_W'(ci); cfg_size_i = 2'(sz);
    cfg_slast_i = 32'(sl); cfg_dlast_i = 32'(dl);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waiting = 1'b1;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    bpm = nb >> sz; total = bpm * ci; cap = BURST >> sz;
    if (rerr >= 0) begin
      chk(err_o == 1'b1, "R9 read error flag", err_o, 1);
      chk(done_cnt == 0, "R9 no done after read error", done_cnt, 0);
      chk(cur_saddr_o == sa + 32'(rerr * so), "R9 saddr held at failing beat", cur_saddr_o, sa + 32'(rerr * so));
      chk(cur_citer_o == CITER_W'(ci - rerr / bpm), "R9 citer after read error", cur_citer_o, ci - rerr / bpm);
    end else if (werr >= 0) begin
      chk(err_o == 1'b1, "R9 write error flag", err_o, 1);
      chk(done_cnt == 0, "R9 no done after write error", done_cnt, 0);
      chk(cur_daddr_o == da + 32'(werr * dof), "R9 daddr held at failing beat", cur_daddr_o, da + 32'(werr * dof));
    end else begin
      chk(err_o == 1'b0 && cfg_err_o == 1'b0, "R8 flags clear after good run", {err_o, cfg_err_o}, 0);
      chk(wr_cnt == total && rd_cnt == total, "R1 beat counts", wr_cnt, total);
      bad = 0;
      for (int k = 0; k < total && k < 1024; k++) begin
        if (wl_addr[k] != da + 32'(k * dof)) bad++;
        if (wl_data[k] != pat(sa + 32'(k * so))) bad++;
      end
      chk(bad == 0, "R2 write addresses and data", bad, 0);
      exp_before = (bpm < cap) ? bpm : cap;
      chk(rd_before == exp_before, "R3 reads staged before first write", rd_before, exp_before);
      chk(minor_cnt == ci, "R4 minor done pulses", minor_cnt, ci);
      chk(grant_viol == 0, "R5 no read before grant", grant_viol, 0);
      chk(done_cnt == 1 && cur_citer_o == 0, "R6 done pulse and zero count", done_cnt, 1);
      chk(cur_saddr_o == sa + 32'(total * so) + 32'(sl), "R7 final source address", cur_saddr_o, sa + 32'(total * so) + 32'(sl));
      chk(cur_daddr_o == da + 32'(total * dof) + 32'(dl), "R7 final dest address", cur_daddr_o, da + 32'(total * dof) + 32'(dl));
    end
  endtask

  task automatic bad_cfg(input int nb, input int ci, input int sz);
    rd_cnt = 0;
    @(negedge clk);
    cfg_nbytes_i = NBYTES_W'(nb); cfg_citer_i = CITER_W'(ci); cfg_size_i = 2'(sz);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(cfg_err_o == 1'b1, "R8 cfg error flagged", cfg_err_o, 1);
    chk(busy_o == 1'b0 && rd_cnt == 0, "R8 no activity on bad cfg", rd_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    rd_err_at = -1; wr_err_at = -1; waiting = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !rd_valid_o && !wr_valid_o && !done_o && !err_o && !cfg_err_o,
        "R6 reset state idle", busy_o, 0);
    rst_ni = 1'b1;
    // directed: 1-byte beats, 40 bytes -> chunks 16,16,8 (R3)
    run(32'h1000, 32'h8000, 1, 1, 40, 3, 0, -120, 16, -1, -1);
    // fixed source register, negative dest stride, word beats
    run(32'h4000_0010, 32'h2000, 0, -4, 24, 2, 2, 0, 64, -1, -1);
    // single word, single iteration
    run(32'h300, 32'h500, 4, 4, 4, 1, 2, 8, -8, -1, -1);
    // halfword beats, 16-byte chunk exactly
    run(32'h600, 32'h900, 2, 2, 16, 2, 1, -32, -32, -1, -1);
    bad_cfg(3, 2, 1);   // R8 not a multiple
    bad_cfg(8, 2, 3);   // R8 reserved size
    bad_cfg(0, 2, 0);   // R8 zero bytes
    bad_cfg(8, 0, 2);   // R8 zero major count
    run(32'h700, 32'hA00, 1, 1, 8, 2, 0, 0, 0, -1, -1);  // clears cfg_err (R8)
    // error injection deep in a later minor loop (R9)
    run(32'h1100, 32'h2200, 4, 4, 12, 4, 2, 0, 0, 7, -1);
    run(32'h1100, 32'h2200, 2, -2, 10, 3, 1, 0, 0, -1, 8);
    // constrained random
    for (int i = 0; i < 8; i++) begin
      int sz, bpm, so, dof;
      sz  = $urandom % 3;
      bpm = 1 + $urandom % 12;
      so  = (int'($urandom % 5) - 2) * (1 << sz);
      dof = (int'($urandom % 5) - 2) * (1 << sz);
      run($urandom & 32'hFFFF_FF00, $urandom & 32'hFFFF_FF00, so, dof,
          bpm << sz, 1 + $urandom % 5, sz, int'($urandom % 256) - 128, int'($urandom % 256) - 128, -1, -1);
    end
    finish_run();
  end
endmodule